// File: doc/BRIEF.md
# Trigger-Gated Interval Timer

This block measures how long a monitored input stays high, with no processor work between the two edges. A synchronizer and edge detector watch the gate pin. A rising edge becomes a one-cycle start trigger that sets the timer running. A falling edge becomes a one-cycle stop trigger, which is brought out as a pin. The timer does not stop on its own. It stops when a register write sets bit 0 of the run-clear register, a write that in a full system comes from a DMA engine fired by the stop trigger.

While the timer runs it counts clock cycles and drives a continuous PWM waveform, whose period and high time come from registers. Every detected edge sets a flag. While a flag is set, no further trigger of that kind is raised, so software must clear the flag before back-to-back triggers can pass. The held count and the flags are read through a small register port with a single address.

All pins are plain control and status signals. The register port has no handshake: a write completes in the cycle it is presented, a read is combinational from the address, and the port never applies back-pressure.

Top module: `gated_span_timer`

## Requirements
- R1: The gate pin passes through a 2-flop synchronizer. When the pin is high at rising edge E1, start_trig_o is high for exactly one cycle, between E2 and E3 (the pin having been low before). The timer acts on this trigger at E3.
- R2: A falling edge on the gate pin raises stop_trig_o for one cycle with the same latency as R1. The stop trigger does not stop the timer.
- R3: A start trigger that arrives while the timer is stopped sets it running and clears the count to 0. The count read back is therefore C−S−1, where S is the start edge and C is the edge of the stopping write.
- R4: While running, the count rises by one on every clock edge except the edge that stops it.
- R5: A write to address 2 (run-clear) with data bit 0 = 1 stops a running timer. A write to that address with bit 0 = 0 has no effect, and so does any run-clear write while the timer is stopped.
- R6: The count is read at address 4. It holds its value after stop until the next accepted start trigger.
- R7: Address 3 reads the edge flags: bit 0 = rise seen, bit 1 = fall seen. An edge sets its flag. While the rise flag is set, no start trigger is raised, and while the fall flag is set, no stop trigger is raised.
- R8: The flags are write-one-to-clear, bit by bit, through a write to address 3. A 0 bit leaves its flag alone. If an edge and a clear reach the same flag in the same cycle, the edge wins.
- R9: A start trigger while the timer is running is ignored. The count keeps rising and is not cleared.
- R10: The PWM period register is at address 0 and the width register at address 1. A phase counter is 0 on the start edge and wraps after period−1 (period 0 behaves as 1). pwm_o is high while running and phase < width, and low while stopped.
- R11: Address 5 bit 0 reads 1 while the timer is running.
- R12: After reset every register reads 0, pwm_o is low and neither trigger is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_pin_i | input | 1 | Monitored pin, asynchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address for both read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| start_trig_o | output | 1 | One-cycle start trigger |
| stop_trig_o | output | 1 | One-cycle stop trigger, meant for a DMA engine |
| pwm_o | output | 1 | PWM waveform while running |

## Verification
The assertions assume that the gate pin is held low through reset and that each level on it lasts at least three clock cycles, so that each edge gives one clean pulse out of the synchronizer. They also assume that only one register write is presented per cycle. The stimulus changes the pin and the bus only on falling clock edges and holds each pin level for three or more cycles. It reads the results back through the register port a half cycle after the edge that produced them.

// File: rtl/span_pkg.sv
package span_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_PERIOD = 3'd0;
  localparam addr_t A_WIDTH  = 3'd1;
  localparam addr_t A_RUNCLR = 3'd2;
  localparam addr_t A_FLAGS  = 3'd3;
  localparam addr_t A_COUNT  = 3'd4;
  localparam addr_t A_STATUS = 3'd5;

  localparam int KIND_RISE = 0;
  localparam int KIND_FALL = 1;
  localparam int NUM_KINDS = 2;
endpackage

// File: rtl/span_edge_unit.sv
module span_edge_unit
  import span_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_i,
  input  logic [NUM_KINDS-1:0] clr_i,
  output logic [NUM_KINDS-1:0] trig_o,
  output logic [NUM_KINDS-1:0] flags_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;
  logic [NUM_KINDS-1:0]   hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level           = sync_q[SYNC_STAGES-1];
  assign hit[KIND_RISE]  = level & ~prev_q;
  assign hit[KIND_FALL]  = ~level & prev_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit[k])   flag_q <= 1'b1;   // a new edge beats a clear
      else if (clr_i[k]) flag_q <= 1'b0;
    end
    assign trig_o[k]  = hit[k] & ~flag_q;
    assign flags_o[k] = flag_q;
  end
endmodule

// File: rtl/span_pwm_core.sv
module span_pwm_core #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              runclr_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [DATA_W-1:0] width_i,
  output logic              running_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o
);
  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] phase_q;
  logic [DATA_W-1:0] last_phase;

  assign last_phase = (period_i == '0) ? '0 : period_i - DATA_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        phase_q <= '0;
      end
    end else if (runclr_i) begin
      run_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
      phase_q <= (phase_q >= last_phase) ? '0 : phase_q + DATA_W'(1);
    end
  end

  assign running_o = run_q;
  assign count_o   = cnt_q;
  assign pwm_o     = run_q && (phase_q < width_i);
endmodule

// File: rtl/span_regs.sv
module span_regs
  import span_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  addr_t                addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 running_i,
  input  logic [NUM_KINDS-1:0] flags_i,
  output logic [DATA_W-1:0]    period_o,
  output logic [DATA_W-1:0]    width_o,
  output logic                 runclr_o,
  output logic [NUM_KINDS-1:0] clr_o
);
  logic [DATA_W-1:0] period_q, width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      width_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_PERIOD) period_q <= wdata_i;
      if (addr_i == A_WIDTH)  width_q  <= wdata_i;
    end
  end

  assign period_o = period_q;
  assign width_o  = width_q;
  assign runclr_o = wr_i && (addr_i == A_RUNCLR) && wdata_i[0];
  assign clr_o    = (wr_i && addr_i == A_FLAGS) ? wdata_i[NUM_KINDS-1:0] : '0;

  always_comb begin
    case (addr_i)
      A_PERIOD: rdata_o = period_q;
      A_WIDTH:  rdata_o = width_q;
      A_FLAGS:  rdata_o = DATA_W'(flags_i);
      A_COUNT:  rdata_o = DATA_W'(count_i);
      A_STATUS: rdata_o = DATA_W'(running_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gated_span_timer.sv
module gated_span_timer
  import span_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_pin_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              start_trig_o,
  output logic              stop_trig_o,
  output logic              pwm_o
);
  logic [NUM_KINDS-1:0] trig, flags, clr;
  logic                 runclr_hit, running;
  logic [CNT_W-1:0]     count;
  logic [DATA_W-1:0]    period, width;

  span_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk, .rst_n, .pin_i(gate_pin_i), .clr_i(clr), .trig_o(trig), .flags_o(flags)
  );

  span_pwm_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk, .rst_n, .start_i(trig[KIND_RISE]), .runclr_i(runclr_hit),
    .period_i(period), .width_i(width), .running_o(running),
    .count_o(count), .pwm_o(pwm_o)
  );

  span_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .count_i(count), .running_i(running), .flags_i(flags),
    .period_o(period), .width_o(width), .runclr_o(runclr_hit), .clr_o(clr)
  );

  assign start_trig_o = trig[KIND_RISE];
  assign stop_trig_o  = trig[KIND_FALL];
endmodule

// File: rtl/span_timer_chk.sv
module span_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_trig,
  input logic             stop_trig,
  input logic             runclr,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             pwm,
  input logic [1:0]       flags
);
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && !running) |=> (running && count == '0));

  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runclr && running) |=> !running);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !runclr) |=> (running && count == $past(count) + CNT_W'(1)));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_trig) |=> $stable(count));

  // R10
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pwm);

  // R7
  rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_trig |=> flags[0]);

  // R7
  fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> flags[1]);
endmodule

bind gated_span_timer span_timer_chk #(.CNT_W(CNT_W)) u_span_chk (
  .clk(clk), .rst_n(rst_n), .start_trig(start_trig_o), .stop_trig(stop_trig_o),
  .runclr(runclr_hit), .running(running), .count(count), .pwm(pwm_o), .flags(flags)
);

// File: tb/gated_span_timer_bench.sv
module gated_span_timer_bench;
  import span_pkg::*;
  localparam int CLK_P = 100;
  localparam int K_REG = 0, K_PWM = 1, K_START = 2, K_STOP = 3;

  logic        clk = 1'b0, rst_n = 1'b0, gate = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        start_trig, stop_trig, pwm;

  gated_span_timer u_gated_span_timer (
    .clk(clk), .rst_n(rst_n), .gate_pin_i(gate), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .start_trig_o(start_trig), .stop_trig_o(stop_trig), .pwm_o(pwm)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { string req; int kind; logic [31:0] val; } item_t;
  item_t sb_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // monitor: pops each expected item and compares with the live outputs
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      case (it.kind)
        K_REG:   act = bus_rdata;
        K_PWM:   act = {31'd0, pwm};
        K_START: act = {31'd0, start_trig};
        default: act = {31'd0, stop_trig};
      endcase
      vectors++;
      if (act !== it.val) begin
        miscompares++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic exp_reg(string req, addr_t a, logic [31:0] v);
    bus_addr = a;
    sb_q.push_back('{req, K_REG, v});
    #1;
  endtask

  task automatic exp_pin(string req, int kind, logic v);
    sb_q.push_back('{req, kind, {31'd0, v}});
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(addr_t a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    for (int a = 0; a < 6; a++) exp_reg("R12", addr_t'(a), 32'd0);
    exp_pin("R12", K_PWM, 1'b0);
    exp_pin("R12", K_START, 1'b0);
    exp_pin("R12", K_STOP, 1'b0);

    bus_write(A_PERIOD, 32'd4);
    bus_write(A_WIDTH, 32'd1);
    exp_reg("R10", A_PERIOD, 32'd4);

    // first measurement
    gate = 1'b1;
    tick(1); exp_pin("R1", K_START, 1'b0);
    tick(1); exp_pin("R1", K_START, 1'b1);
    tick(1);                                  // start edge S
    exp_pin("R1", K_START, 1'b0);
    exp_reg("R11", A_STATUS, 32'd1);
    exp_reg("R3", A_COUNT, 32'd0);
    exp_pin("R10", K_PWM, 1'b1);
    tick(1);                                  // S+1
    exp_reg("R4", A_COUNT, 32'd1);
    exp_pin("R10", K_PWM, 1'b0);
    tick(3);                                  // S+4
    exp_pin("R10", K_PWM, 1'b1);
    exp_reg("R4", A_COUNT, 32'd4);
    gate = 1'b0;
    tick(2);                                  // S+6
    exp_pin("R2", K_STOP, 1'b1);
    tick(1);                                  // S+7
    exp_pin("R2", K_STOP, 1'b0);
    exp_reg("R2", A_STATUS, 32'd1);
    bus_write(A_RUNCLR, 32'd1);               // acts at S+8
    exp_reg("R5", A_STATUS, 32'd0);
    exp_reg("R3", A_COUNT, 32'd7);
    exp_reg("R7", A_FLAGS, 32'd3);
    tick(3);
    exp_reg("R6", A_COUNT, 32'd7);
    exp_pin("R10", K_PWM, 1'b0);
    bus_write(A_RUNCLR, 32'd1);
    exp_reg("R5", A_STATUS, 32'd0);
    exp_reg("R5", A_COUNT, 32'd7);

    // flags still set: no new triggers
    gate = 1'b1;
    tick(2); exp_pin("R7", K_START, 1'b0);
    tick(2);
    exp_reg("R7", A_STATUS, 32'd0);
    exp_reg("R6", A_COUNT, 32'd7);
    gate = 1'b0;
    tick(2); exp_pin("R7", K_STOP, 1'b0);
    tick(2);
    bus_write(A_FLAGS, 32'd1);
    exp_reg("R8", A_FLAGS, 32'd2);
    bus_write(A_FLAGS, 32'd2);
    exp_reg("R8", A_FLAGS, 32'd0);

    // second measurement, new waveform
    bus_write(A_PERIOD, 32'd3);
    bus_write(A_WIDTH, 32'd2);
    gate = 1'b1;
    tick(3);                                  // S
    exp_reg("R3", A_COUNT, 32'd0);
    exp_pin("R10", K_PWM, 1'b1);
    tick(1); exp_pin("R10", K_PWM, 1'b1);
    tick(1); exp_pin("R10", K_PWM, 1'b0);
    tick(1); exp_pin("R10", K_PWM, 1'b1);    // S+3
    bus_write(A_FLAGS, 32'd1);                // now at S+4
    gate = 1'b0;
    tick(3);                                  // S+7
    gate = 1'b1;
    tick(2); exp_pin("R9", K_START, 1'b1);   // S+9
    tick(1);                                  // S+10
    exp_reg("R9", A_STATUS, 32'd1);
    exp_reg("R9", A_COUNT, 32'd10);
    bus_write(A_RUNCLR, 32'd0);               // S+11
    exp_reg("R5", A_STATUS, 32'd1);
    exp_reg("R5", A_COUNT, 32'd11);
    bus_write(A_RUNCLR, 32'd1);               // stops at S+12
    exp_reg("R5", A_STATUS, 32'd0);
    exp_reg("R3", A_COUNT, 32'd11);

    // restart clears count; immediate stop
    gate = 1'b0;
    tick(3);
    bus_write(A_FLAGS, 32'd3);
    gate = 1'b1;
    tick(3);
    exp_reg("R3", A_STATUS, 32'd1);
    exp_reg("R3", A_COUNT, 32'd0);
    bus_write(A_RUNCLR, 32'd1);
    exp_reg("R3", A_COUNT, 32'd0);
    exp_reg("R5", A_STATUS, 32'd0);

    tick(1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule